// File: doc/BRIEF.md
# PHY Register Write Handshake Bridge

The bridge gives a host one 32-bit control word for placing single bytes into a register file on the PHY side. The host writes a PHY register index, a data byte and a request flag into this word. The bridge captures the index and the byte, issues one write strobe toward the PHY, and waits for the PHY's ready pulse. It then raises an acknowledge flag that the host can read back from the same word.

The acknowledge flag stays high for as long as the request flag is set. It drops only after the host clears the request, which completes a four-phase exchange. A request bit written while the bridge is busy or acknowledging is stored for readback, but it does not start a second PHY write. The host must see acknowledge at 0 before it sets the request again.

Top module: `phy_wr_bridge`

## Requirements
- R1: The control word holds the PHY register index in bits 5:0, the data byte in bits 15:8 and the request flag in bit 24. Each host write loads these fields, and reading the word returns them.
- R2: Bit 26 reads as the acknowledge flag, and host writes to it are ignored. All other bits (31:27, 25, 23:16, 7:6) read as 0 whatever the host writes into them.
- R3: After a synchronous active-high reset, the control word reads 0 and no strobe is issued.
- R4: A host write with bit 24 set, made while the bridge is idle (acknowledge low, no write in flight), makes `phy_wr_strb` high in the next cycle. In that cycle `phy_addr` and `phy_data` carry the index and byte from that write.
- R5: Each accepted request produces a strobe lasting exactly one cycle. Holding the request high, or writing it again, produces no further strobe.
- R6: Acknowledge rises in the cycle after `phy_ready` is sampled high while the bridge waits for the PHY. A ready pulse in the strobe cycle is ignored.
- R7: Acknowledge stays high while the request flag reads 1. It falls at the first clock edge at which the request flag reads 0.
- R8: A request bit written while acknowledge is high starts no PHY write, even after acknowledge falls. A new write starts only when bit 24 is written again while the bridge is idle.
- R9: Index and byte changes written after a request is accepted do not alter `phy_addr` or `phy_data` for that write. They do appear in the readback.
- R10: A `phy_ready` pulse while no write is pending does not raise acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write enable for the control word |
| host_wdata | input | 32 | Host write value |
| host_rdata | output | 32 | Control word readback |
| phy_wr_strb | output | 1 | One-cycle PHY write strobe |
| phy_addr | output | ADDR_W | PHY register index of the write |
| phy_data | output | DATA_W | PHY write byte |
| phy_ready | input | 1 | PHY write completion pulse |

## Verification
A host write to the control word can land in the same cycle as a change in the handshake state. One case is a new request bit arriving on the edge where acknowledge falls. Another is new index and byte values arriving in the strobe cycle, together with a ready pulse. The bench forces both on purpose: a clear-then-set pair of host writes on consecutive edges, and a random rewrite of the fields with a random ready level during the strobe. It then judges the result by counting strobes and by comparing the PHY-side address and data against the values captured when the request was accepted.

// File: rtl/phy_wr_bridge.sv
module phy_wr_bridge #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              phy_wr_strb,
  output logic [ADDR_W-1:0] phy_addr,
  output logic [DATA_W-1:0] phy_data,
  input  logic              phy_ready
);
  localparam int DATA_LSB = 8;
  localparam int REQ_BIT  = 24;
  localparam int ACK_BIT  = 26;
  localparam logic [31:0] FIELD_MASK = ((32'd1 << ADDR_W) - 32'd1)
                                     | (((32'd1 << DATA_W) - 32'd1) << DATA_LSB)
                                     | (32'd1 << REQ_BIT);

  typedef enum logic [2:0] {IDLE, WRITE, WAIT_READY, ACK, WAIT_REQ_LOW} st_t;
  st_t st;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              req_q;
  logic              ack;
  logic              start;
  logic              unused_wr;

  assign ack         = (st == ACK) || (st == WAIT_REQ_LOW);
  assign start       = host_we && host_wdata[REQ_BIT] && (st == IDLE);
  assign phy_wr_strb = (st == WRITE);
  assign unused_wr   = ^(host_wdata & ~FIELD_MASK);

  always_comb begin
    host_rdata                        = '0;
    host_rdata[ADDR_W-1:0]            = addr_q;
    host_rdata[DATA_LSB +: DATA_W]    = data_q;
    host_rdata[REQ_BIT]               = req_q;
    host_rdata[ACK_BIT]               = ack;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      data_q   <= '0;
      req_q    <= 1'b0;
      phy_addr <= '0;
      phy_data <= '0;
      st       <= IDLE;
    end else begin
      if (host_we) begin
        addr_q <= host_wdata[ADDR_W-1:0];
        data_q <= host_wdata[DATA_LSB +: DATA_W];
        req_q  <= host_wdata[REQ_BIT];
      end
      if (start) begin
        phy_addr <= host_wdata[ADDR_W-1:0];
        phy_data <= host_wdata[DATA_LSB +: DATA_W];
      end
      case (st)
        IDLE:         if (start) st <= WRITE;
        WRITE:        st <= WAIT_READY;
        WAIT_READY:   if (phy_ready) st <= ACK;
        ACK,
        WAIT_REQ_LOW: st <= req_q ? WAIT_REQ_LOW : IDLE;
        default:      st <= IDLE;
      endcase
    end
  end
endmodule

module phy_wr_bridge_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_req,
  input logic              req_rd,
  input logic              ack_rd,
  input logic              word_zero,
  input logic              phy_wr_strb,
  input logic [ADDR_W-1:0] phy_addr,
  input logic [DATA_W-1:0] phy_data,
  input logic              phy_ready
);
  // R3
  reset_clear_chk: assert property (@(posedge clk) rst |=> (word_zero && !phy_wr_strb));

  // R4
  strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
    phy_wr_strb |-> $past(wr_req && !ack_rd));

  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    phy_wr_strb |=> !phy_wr_strb);

  // R6
  ack_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_rd) |-> $past(phy_ready));

  // R7
  ack_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_rd) |-> !$past(req_rd));

  // R8
  no_strobe_acked_chk: assert property (@(posedge clk) disable iff (rst)
    phy_wr_strb |-> !ack_rd);

  // R9
  hold_fields_chk: assert property (@(posedge clk) disable iff (rst)
    ack_rd |-> ($stable(phy_addr) && $stable(phy_data)));
endmodule

bind phy_wr_bridge phy_wr_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_req      (host_we && host_wdata[24]),
  .req_rd      (host_rdata[24]),
  .ack_rd      (host_rdata[26]),
  .word_zero   (host_rdata == 32'd0),
  .phy_wr_strb (phy_wr_strb),
  .phy_addr    (phy_addr),
  .phy_data    (phy_data),
  .phy_ready   (phy_ready)
);

// File: tb/phy_wr_bridge_tb.sv
module phy_wr_bridge_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        host_we;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic        phy_wr_strb;
  logic [5:0]  phy_addr;
  logic [7:0]  phy_data;
  logic        phy_ready;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [5:0] e_addr;
  logic [7:0] e_data;
  logic       e_req;
  logic [7:0] phy_mem [64];
  logic [7:0] shadow  [64];

  always #10 clk = ~clk;

  phy_wr_bridge u_dut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .phy_wr_strb(phy_wr_strb), .phy_addr(phy_addr),
    .phy_data(phy_data), .phy_ready(phy_ready)
  );

  always @(posedge clk) if (phy_wr_strb) phy_mem[phy_addr] <= phy_data;

  function automatic logic [31:0] exp_word(input logic ack);
    logic [31:0] w = '0;
    w[5:0] = e_addr; w[15:8] = e_data; w[24] = e_req; w[26] = ack;
    return w;
  endfunction

  function automatic logic [31:0] mk_word(input logic [5:0] a, input logic [7:0] d, input logic r);
    logic [31:0] w = $urandom;
    w[5:0] = a; w[15:8] = d; w[24] = r;
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic host_wr(input logic [31:0] w);
    host_we = 1'b1; host_wdata = w;
    tick();
    host_we = 1'b0;
    e_addr = w[5:0]; e_data = w[15:8]; e_req = w[24];
  endtask

  task automatic txn(input logic [5:0] a, input logic [7:0] d, input int lat, input int hold, input bit rewrite);
    host_wr(mk_word(a, d, 1'b1));
    chk(phy_wr_strb === 1'b1, "R4 strobe", {31'd0, phy_wr_strb}, 32'd1);
    chk(phy_addr === a && phy_data === d, "R4 addr/data", {18'd0, phy_addr, phy_data}, {18'd0, a, d});
    chk(host_rdata === exp_word(1'b0), "R1 R2 readback", host_rdata, exp_word(1'b0));
    phy_ready = $urandom_range(0, 1);
    if (rewrite) host_wr(mk_word(6'($urandom), 8'($urandom), 1'b1));
    else tick();
    phy_ready = 1'b0;
    chk(!phy_wr_strb && !host_rdata[26], "R5 R6 after strobe", host_rdata, exp_word(1'b0));
    chk(phy_addr === a && phy_data === d, "R9 fields held", {18'd0, phy_addr, phy_data}, {18'd0, a, d});
    chk(host_rdata === exp_word(1'b0), "R9 readback new fields", host_rdata, exp_word(1'b0));
    for (int i = 0; i < lat; i++) begin
      tick();
      chk(!host_rdata[26] && !phy_wr_strb, "R6 waiting", host_rdata, exp_word(1'b0));
    end
    phy_ready = 1'b1;
    tick();
    phy_ready = 1'b0;
    chk(host_rdata === exp_word(1'b1), "R6 ack raised", host_rdata, exp_word(1'b1));
    for (int i = 0; i < hold; i++) begin
      if (i == 1) host_wr(mk_word(6'($urandom), 8'($urandom), 1'b1));
      else tick();
      chk(host_rdata[26] && !phy_wr_strb, "R5 R7 ack held", host_rdata, exp_word(1'b1));
      chk(phy_addr === a && phy_data === d, "R9 held while ack", {18'd0, phy_addr, phy_data}, {18'd0, a, d});
    end
    host_wr(mk_word(6'($urandom), 8'($urandom), 1'b0));
    chk(host_rdata === exp_word(1'b1), "R7 ack until req seen low", host_rdata, exp_word(1'b1));
    tick();
    chk(host_rdata === exp_word(1'b0), "R7 ack dropped", host_rdata, exp_word(1'b0));
    shadow[a] = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 64; i++) begin phy_mem[i] = 8'h00; shadow[i] = 8'h00; end
    rst = 1'b1; host_we = 1'b0; host_wdata = '0; phy_ready = 1'b0;
    e_addr = '0; e_data = '0; e_req = 1'b0;
    repeat (3) tick();
    chk(host_rdata === 32'd0 && !phy_wr_strb, "R3 reset", host_rdata, 32'd0);
    rst = 1'b0;
    tick();

    // R2: every bit written 1 with request clear
    host_wr(32'hFFFF_FFFF & ~(32'd1 << 24));
    chk(host_rdata === exp_word(1'b0), "R2 unused and ack bits", host_rdata, exp_word(1'b0));
    chk(host_rdata === 32'h0000_FF3F, "R1 R2 fixed layout", host_rdata, 32'h0000_FF3F);

    // R10: ready with nothing pending
    phy_ready = 1'b1; tick(); phy_ready = 1'b0; tick();
    chk(!host_rdata[26] && !phy_wr_strb, "R10 idle ready ignored", host_rdata, exp_word(1'b0));

    // directed corners: address 0 and 63, zero latency, zero hold
    txn(6'd0, 8'hA5, 0, 0, 1'b0);
    txn(6'd63, 8'h5A, 4, 3, 1'b1);

    // R8: clear and re-set on consecutive edges while ack high
    host_wr(mk_word(6'd17, 8'h3C, 1'b1));
    tick(); phy_ready = 1'b1; tick(); phy_ready = 1'b0;
    chk(host_rdata[26] === 1'b1, "R6 ack before R8 case", host_rdata, exp_word(1'b1));
    host_wr(mk_word(6'd17, 8'h3C, 1'b0));
    host_wr(mk_word(6'd22, 8'h99, 1'b1));
    for (int i = 0; i < 4; i++) begin
      chk(!phy_wr_strb && !host_rdata[26], "R8 no new write", host_rdata, exp_word(1'b0));
      tick();
    end
    chk(host_rdata === exp_word(1'b0), "R8 request stored", host_rdata, exp_word(1'b0));
    shadow[17] = 8'h3C;
    host_wr(mk_word(6'd22, 8'h99, 1'b0));
    tick();
    txn(6'd22, 8'h99, 2, 1, 1'b0);

    for (int t = 0; t < 40; t++)
      txn(6'($urandom), 8'($urandom), $urandom_range(0, 6), $urandom_range(0, 4), 1'($urandom));

    tick();
    begin
      int diffs = 0;
      for (int i = 0; i < 64; i++) if (phy_mem[i] !== shadow[i]) diffs++;
      chk(diffs == 0, "R4 R9 PHY register contents", diffs, 0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule